// File: doc/BRIEF.md
# Eight-Level Programmable Interrupt Controller

This block gathers eight interrupt request lines, ranks them, and raises a single interrupt line toward a processor. Software drives it through a byte-wide bus with two addresses. Address 0 is the command port. Address 1 is the data port. After reset the block stays silent until software writes a start-up word sequence. That sequence sets the vector base, the trigger style and the completion style. From then on, data-port writes load the mask. Command-port writes either retire in-service levels, change the rotation of priorities, pick which register a command-port read returns, or enter poll or special-mask operation.

When the processor acknowledges, the block returns an 8-bit vector, equal to the programmed base plus the winning level, on the cycle after the acknowledge. It also moves that level from pending to in service. End-of-interrupt can be explicit, or automatic at the acknowledge. Priority is either fixed, with level 0 highest, or rotating, with a movable lowest-priority level. Only one device is modelled. The cascade configuration byte is kept and presented on a port for neighbouring logic, but no cascade wiring is built.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the block is uninitialised, `int_req` is 0, `vec_out` is 0x00, and both ports read 0x00.
- R2: A command write with bit 4 set starts initialisation. It clears the in-service, pending and mask registers, restores fixed order (level 0 highest), and clears special mask and auto end-of-interrupt; it also selects pending as the command-port read. The next data write is the vector base. A cascade byte follows only when bit 1 of the start word is 0. A mode word follows only when bit 0 is 1. `int_req` stays 0 until the sequence is complete.
- R3: Once initialised, a data-port write loads the mask, where bit n = 1 blocks level n from `int_req` (the pending bit is still recorded). A data-port read returns the mask.
- R4: Start-word bit 3 = 0 gives edge capture: a 0→1 input change sets the pending bit, and acknowledge clears it. Bit 3 = 1 gives level capture: the pending register follows the inputs each cycle.
- R5: `int_req` is 1 only when an unmasked pending level outranks every in-service level.
- R6: On `int_ack` with `int_req` high, `vec_out` becomes base + level on the next cycle, the level's in-service bit is set, and its pending bit is cleared. With `int_req` low, `vec_out` becomes base + 7 and no other state changes.
- R7: Command bytes with bit 4 = 0 are decoded on bits 4:3, where 00 is a completion/priority word and 01 is a read/mode word. Word 0x20 clears the highest-ranked in-service bit. Word 0x60|L clears in-service bit L.
- R8: Word 0xC0|L makes L the lowest priority. 0xA0 acts as 0x20 and then makes the cleared level lowest. 0xE0|L acts as 0x60|L and then makes L lowest.
- R9: Mode-word bit 1 = 1 selects automatic completion, where acknowledge does not set the in-service bit. Words 0x80 and 0x00 enable and disable rotation on automatic completion, which makes the acknowledged level lowest.
- R10: Word 0x0A makes command-port reads return the pending register. Word 0x0B makes them return the in-service register.
- R11: Word 0x0C makes the next command-port read return bit 7 = request present and bits 2:0 = winning level. That read acts as an acknowledge.
- R12: Word 0x68 enables special mask mode, where any unmasked pending level that is not in service may raise `int_req` whatever is in service. Word 0x48 disables it.
- R13: Mode-word bit 4 = 1 selects special fully nested operation, where a new request on the level already in service also raises `int_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_addr | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| irq_in | input | 8 | Request inputs, level n on bit n |
| int_ack | input | 1 | Acknowledge pulse from the processor |
| int_req | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector captured at the last acknowledge |
| casc_cfg | output | 8 | Stored cascade configuration byte |

## Verification
The hardest state to reach is one where a request is blocked only by in-service state under a rotated order. Examples are a level-7 service holding off level 0 after rotation, or special mask mode releasing it. Reaching that state needs a full start-up sequence, then a rotate-on-completion word, then two inputs rising in the same cycle, and only then an acknowledge. The stimulus table builds this up step by step and checks `int_req` and the register reads at every stage. The automatic-completion, level-capture and fully nested cases each need a fresh start-up sequence, so each is handled by its own directed segment.

// File: rtl/irqc_pkg.sv
// Package: shared types for the eight-level interrupt controller.
// Assumes the command byte layout described in the brief.
package irqc_pkg;
    // Start-up sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE, ST_BASE, ST_CASC, ST_MODE, ST_RUN
    } init_st_e;

    // Completion/priority word operation, taken from command bits 7:5.
    typedef enum logic [2:0] {
        OP_ROT_AUTO_OFF = 3'b000,
        OP_EOI_ANY      = 3'b001,
        OP_NOP          = 3'b010,
        OP_EOI_LVL      = 3'b011,
        OP_ROT_AUTO_ON  = 3'b100,
        OP_EOI_ANY_ROT  = 3'b101,
        OP_SET_LOW      = 3'b110,
        OP_EOI_LVL_ROT  = 3'b111
    } cmp_op_e;
endpackage

// File: rtl/irqc_prio_find.sv
// Module: rotating priority finder.
// Finds the highest-ranked set bit of vec, where the level just above `low`
// ranks 0. Assumes N is a power of two. With no bit set: any=0, lvl=0, rank=N.
module irqc_prio_find #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    input  logic [LW-1:0] low,
    output logic          any,
    output logic [LW-1:0] lvl,
    output logic [LW:0]   rank
);
    localparam int RW = LW + 1;

    logic [LW-1:0] idx;

    // Scan ranks from lowest to highest so the highest-ranked hit wins.
    always_comb begin
        any  = 1'b0;
        lvl  = '0;
        rank = RW'(N);
        idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            idx = LW'(low + LW'(1) + LW'(i));
            if (vec[idx]) begin
                any  = 1'b1;
                lvl  = idx;
                rank = RW'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_req_latch.sv
// Module: request capture. Edge mode records rising inputs until they are
// acknowledged; level mode copies the inputs every cycle.
module irqc_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic         level_mode,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] irr
);
    logic [N-1:0] prev;
    logic [N-1:0] rise;

    assign rise = irq_in & ~prev;

    // Remember last input sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= irq_in;
    end

    // Update the pending register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) irr <= '0;
        else if (level_mode)   irr <= irq_in;
        else                   irr <= (irr | rise) & ~ack_clr;
    end

    // R4: in edge mode a rising input not being cleared is pending next cycle.
    assert_edge_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && !clr_all && ((rise & ~ack_clr) != '0))
        |=> ((irr & $past(rise & ~ack_clr)) == $past(rise & ~ack_clr)));
endmodule

// File: rtl/irqc_cfg_seq.sv
// Module: bus decode, start-up sequencer and configuration registers.
// Assumes single-cycle strobes. Completion and read/mode words are accepted
// only once start-up is complete.
module irqc_cfg_seq
    import irqc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          ready,
    output logic          init_pulse,
    output logic [DW-1:0] base,
    output logic [DW-1:0] casc,
    output logic [DW-1:0] imr,
    output logic          level_mode,
    output logic          auto_eoi,
    output logic          nested,
    output logic          smm,
    output logic          rd_isr,
    output logic          poll_pend,
    output logic          poll_rd,
    output logic          rot_auto,
    output logic          cmp_valid,
    output cmp_op_e       cmp_op,
    output logic [2:0]    cmp_lvl
);
    init_st_e st;
    logic     single, need_mode;
    logic     cmd_wr, dat_wr, rw_word;

    assign cmd_wr     = bus_wr & ~bus_addr;
    assign dat_wr     = bus_wr & bus_addr;
    assign ready      = (st == ST_RUN);
    assign init_pulse = cmd_wr & bus_wdata[4];
    assign cmp_valid  = cmd_wr & ~bus_wdata[4] & ~bus_wdata[3] & ready;
    assign rw_word    = cmd_wr & ~bus_wdata[4] & bus_wdata[3] & ready;
    assign cmp_op     = cmp_op_e'(bus_wdata[7:5]);
    assign cmp_lvl    = bus_wdata[2:0];
    assign poll_rd    = bus_rd & ~bus_addr & poll_pend;

    // Step the start-up sequence and store its words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; single <= 1'b0; need_mode <= 1'b0; level_mode <= 1'b0;
            base <= '0; casc <= '0; auto_eoi <= 1'b0; nested <= 1'b0;
        end else if (init_pulse) begin
            st         <= ST_BASE;
            level_mode <= bus_wdata[3];
            single     <= bus_wdata[1];
            need_mode  <= bus_wdata[0];
            auto_eoi   <= 1'b0;
            nested     <= 1'b0;
        end else if (dat_wr) begin
            case (st)
                ST_BASE: begin
                    base <= bus_wdata;
                    st   <= !single ? ST_CASC : (need_mode ? ST_MODE : ST_RUN);
                end
                ST_CASC: begin
                    casc <= bus_wdata;
                    st   <= need_mode ? ST_MODE : ST_RUN;
                end
                ST_MODE: begin
                    auto_eoi <= bus_wdata[1];
                    nested   <= bus_wdata[4];
                    st       <= ST_RUN;
                end
                default: ;
            endcase
        end
    end

    // Load the mask from data writes after start-up.
    always_ff @(posedge clk) begin
        if (!rst_n || init_pulse)  imr <= '0;
        else if (dat_wr && ready)  imr <= bus_wdata;
    end

    // Handle read-select, poll and special-mask words.
    always_ff @(posedge clk) begin
        if (!rst_n || init_pulse) begin
            rd_isr <= 1'b0; smm <= 1'b0; poll_pend <= 1'b0;
        end else if (rw_word) begin
            if (bus_wdata[1]) rd_isr <= bus_wdata[0];
            if (bus_wdata[6]) smm    <= bus_wdata[5];
            poll_pend <= bus_wdata[2];
        end else if (poll_rd) begin
            poll_pend <= 1'b0;
        end
    end

    // Enable or disable rotation on automatic completion.
    always_ff @(posedge clk) begin
        if (!rst_n || init_pulse)                          rot_auto <= 1'b0;
        else if (cmp_valid && cmp_op == OP_ROT_AUTO_ON)    rot_auto <= 1'b1;
        else if (cmp_valid && cmp_op == OP_ROT_AUTO_OFF)   rot_auto <= 1'b0;
    end

    // R2: a start word always leaves the block not ready.
    assert_init_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> !ready);
    // R2: base write in single mode without a mode word finishes start-up.
    assert_skip_words_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BASE && dat_wr && !init_pulse && single && !need_mode) |=> ready);
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: top of the eight-level interrupt controller. Holds in-service state,
// rotation point and vector; ties capture, configuration and ranking together.
// Assumes at most one of acknowledge or completion word per cycle per level.
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int DW      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               int_ack,
    output logic               int_req,
    output logic [DW-1:0]      vec_out,
    output logic [DW-1:0]      casc_cfg
);
    localparam int LW = $clog2(NUM_IRQ);
    localparam int NF = 2;              // finder 0: requests, finder 1: in-service
    localparam logic [LW-1:0] LOW_RST = LW'(NUM_IRQ - 1);

    logic ready, init_pulse, level_mode, auto_eoi, nested, smm, rd_isr;
    logic poll_pend, poll_rd, rot_auto, cmp_valid;
    cmp_op_e cmp_op;
    logic [2:0]         cmp_lvl;
    logic [DW-1:0]      base, imr;
    logic [NUM_IRQ-1:0] irr, isr, ack_clr, isr_set, isr_clr, cand;
    logic [LW-1:0]      low_pri;
    logic [NUM_IRQ-1:0] f_vec  [NF];
    logic               f_any  [NF];
    logic [LW-1:0]      f_lvl  [NF];
    logic [LW:0]        f_rank [NF];
    logic               pass, take;

    irqc_cfg_seq #(.DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ready(ready),
        .init_pulse(init_pulse), .base(base), .casc(casc_cfg), .imr(imr),
        .level_mode(level_mode), .auto_eoi(auto_eoi), .nested(nested),
        .smm(smm), .rd_isr(rd_isr), .poll_pend(poll_pend), .poll_rd(poll_rd),
        .rot_auto(rot_auto), .cmp_valid(cmp_valid), .cmp_op(cmp_op),
        .cmp_lvl(cmp_lvl)
    );

    irqc_req_latch #(.N(NUM_IRQ)) u_req (
        .clk(clk), .rst_n(rst_n), .clr_all(init_pulse), .level_mode(level_mode),
        .irq_in(irq_in), .ack_clr(ack_clr), .irr(irr)
    );

    assign cand     = smm ? (irr & ~imr & ~isr) : (irr & ~imr);
    assign f_vec[0] = cand;
    assign f_vec[1] = isr;

    for (genvar g = 0; g < NF; g++) begin : g_find
        irqc_prio_find #(.N(NUM_IRQ), .LW(LW)) u_find (
            .vec(f_vec[g]), .low(low_pri), .any(f_any[g]),
            .lvl(f_lvl[g]), .rank(f_rank[g])
        );
    end

    // Decide whether the best request may interrupt current service.
    always_comb begin
        pass = f_any[0] && (smm || !f_any[1] || (f_rank[0] < f_rank[1])
                            || (nested && f_rank[0] == f_rank[1]));
    end

    assign int_req = ready & pass;
    assign take    = int_req & (int_ack | poll_rd);
    assign ack_clr = take ? (NUM_IRQ'(1) << f_lvl[0]) : '0;
    assign isr_set = (take && !auto_eoi) ? (NUM_IRQ'(1) << f_lvl[0]) : '0;

    // Select which in-service bit a completion word retires.
    always_comb begin
        isr_clr = '0;
        if (cmp_valid) begin
            case (cmp_op)
                OP_EOI_ANY, OP_EOI_ANY_ROT:
                    if (f_any[1]) isr_clr = NUM_IRQ'(1) << f_lvl[1];
                OP_EOI_LVL, OP_EOI_LVL_ROT:
                    isr_clr = NUM_IRQ'(1) << cmp_lvl;
                default: ;
            endcase
        end
    end

    // Maintain the in-service register.
    always_ff @(posedge clk) begin
        if (!rst_n || init_pulse) isr <= '0;
        else                      isr <= (isr | isr_set) & ~isr_clr;
    end

    // Move the lowest-priority point on rotate commands.
    always_ff @(posedge clk) begin
        if (!rst_n || init_pulse) begin
            low_pri <= LOW_RST;
        end else if (cmp_valid && cmp_op == OP_EOI_ANY_ROT) begin
            if (f_any[1]) low_pri <= f_lvl[1];
        end else if (cmp_valid && (cmp_op == OP_EOI_LVL_ROT || cmp_op == OP_SET_LOW)) begin
            low_pri <= LW'(cmp_lvl);
        end else if (take && auto_eoi && rot_auto) begin
            low_pri <= f_lvl[0];
        end
    end

    // Capture the vector on acknowledge; no request yields base + 7.
    always_ff @(posedge clk) begin
        if (!rst_n)       vec_out <= '0;
        else if (int_ack) vec_out <= base + (int_req ? DW'(f_lvl[0]) : DW'(NUM_IRQ - 1));
    end

    // Read multiplexer for both ports.
    always_comb begin
        if (bus_addr)       bus_rdata = imr;
        else if (poll_pend) bus_rdata = {int_req, {(DW - LW - 1){1'b0}}, f_lvl[0]};
        else if (rd_isr)    bus_rdata = DW'(isr);
        else                bus_rdata = DW'(irr);
    end

    // R2: start word empties the in-service register.
    assert_init_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> (isr == '0));
    // R6: a taken acknowledge marks its level in service unless auto completion.
    assert_ack_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_req && !auto_eoi && !cmp_valid && !init_pulse)
        |=> isr[$past(f_lvl[0])]);
    // R6: acknowledge without a request returns base + 7.
    assert_spurious_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_req) |=> (vec_out == $past(base) + DW'(NUM_IRQ - 1)));
    // R7: any-level completion retires the top in-service level.
    assert_eoi_any_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_op == OP_EOI_ANY && f_any[1] && !take)
        |=> !isr[$past(f_lvl[1])]);
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0, int_ack = 1'b0;
    logic [7:0] bus_wdata = 8'h00, irq_in = 8'h00;
    logic [7:0] bus_rdata, vec_out, casc_cfg;
    logic       int_req;
    int         n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_prio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .int_ack(int_ack), .int_req(int_req),
        .vec_out(vec_out), .casc_cfg(casc_cfg)
    );

    localparam logic [2:0] WC = 3'd0, WD = 3'd1, SI = 3'd2, AK = 3'd3,
                           RC = 3'd4, RD = 3'd5, IN = 3'd6;

    // {op, data, expected, requirement}
    localparam logic [22:0] TBL [0:62] = '{
        {WC, 8'h13, 8'h00, 4'd2},  // R2 start: single, mode word follows
        {WD, 8'h40, 8'h00, 4'd2},  // R2 base
        {WD, 8'h01, 8'h00, 4'd2},  // R2 mode word
        {WD, 8'h00, 8'h00, 4'd3},  // R3 mask clear
        {IN, 8'h00, 8'h00, 4'd5},  // R5 idle
        {SI, 8'h28, 8'h00, 4'd4},
        {IN, 8'h00, 8'h01, 4'd5},  // R5
        {WC, 8'h0A, 8'h00, 4'd10},
        {RC, 8'h00, 8'h28, 4'd10}, // R10 pending read
        {AK, 8'h00, 8'h43, 4'd6},  // R6 level 3
        {IN, 8'h00, 8'h00, 4'd5},  // R5 level 5 blocked
        {WC, 8'h0B, 8'h00, 4'd10},
        {RC, 8'h00, 8'h08, 4'd6},  // R6 in service
        {WC, 8'h20, 8'h00, 4'd7},
        {IN, 8'h00, 8'h01, 4'd7},  // R7
        {AK, 8'h00, 8'h45, 4'd6},
        {SI, 8'h2A, 8'h00, 4'd4},  // R4 only bit 1 rises
        {IN, 8'h00, 8'h01, 4'd5},
        {AK, 8'h00, 8'h41, 4'd5},  // R5 nesting
        {RC, 8'h00, 8'h22, 4'd6},
        {WC, 8'h65, 8'h00, 4'd7},
        {RC, 8'h00, 8'h02, 4'd7},  // R7 specific
        {WC, 8'h20, 8'h00, 4'd7},
        {RC, 8'h00, 8'h00, 4'd7},
        {WD, 8'h01, 8'h00, 4'd3},
        {SI, 8'h00, 8'h00, 4'd4},
        {SI, 8'h01, 8'h00, 4'd4},
        {IN, 8'h00, 8'h00, 4'd3},  // R3 masked
        {RD, 8'h00, 8'h01, 4'd3},  // R3 mask read
        {WC, 8'h0A, 8'h00, 4'd10},
        {RC, 8'h00, 8'h01, 4'd3},  // R3 still recorded
        {WD, 8'h00, 8'h00, 4'd3},
        {IN, 8'h00, 8'h01, 4'd3},
        {AK, 8'h00, 8'h40, 4'd6},
        {WC, 8'h20, 8'h00, 4'd7},
        {WC, 8'hC3, 8'h00, 4'd8},  // R8 lowest = 3
        {SI, 8'h00, 8'h00, 4'd4},
        {SI, 8'h21, 8'h00, 4'd4},
        {AK, 8'h00, 8'h45, 4'd8},  // R8 level 5 beats 0
        {WC, 8'hA0, 8'h00, 4'd8},  // R8 lowest = 5
        {AK, 8'h00, 8'h40, 4'd8},
        {WC, 8'h20, 8'h00, 4'd7},
        {SI, 8'h00, 8'h00, 4'd4},
        {SI, 8'h04, 8'h00, 4'd4},
        {WC, 8'h0C, 8'h00, 4'd11},
        {RC, 8'h00, 8'h82, 4'd11}, // R11 poll
        {WC, 8'h0B, 8'h00, 4'd10},
        {RC, 8'h00, 8'h04, 4'd11}, // R11 poll acknowledged
        {WC, 8'h20, 8'h00, 4'd7},
        {WC, 8'h0C, 8'h00, 4'd11},
        {RC, 8'h00, 8'h00, 4'd11}, // R11 empty poll
        {SI, 8'h00, 8'h00, 4'd4},
        {SI, 8'h81, 8'h00, 4'd4},
        {AK, 8'h00, 8'h47, 4'd8},  // R8 level 7 beats 0 after rotation
        {IN, 8'h00, 8'h00, 4'd5},
        {WC, 8'h68, 8'h00, 4'd12},
        {IN, 8'h00, 8'h01, 4'd12}, // R12 special mask
        {WC, 8'h48, 8'h00, 4'd12},
        {IN, 8'h00, 8'h00, 4'd12},
        {WC, 8'h20, 8'h00, 4'd7},
        {IN, 8'h00, 8'h01, 4'd7},
        {AK, 8'h00, 8'h40, 4'd6},
        {WC, 8'h20, 8'h00, 4'd7}
    };

    task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic set_in(input logic [7:0] d);
        @(negedge clk); irq_in = d;
        @(posedge clk); #1;
    endtask

    task automatic rd_chk(input logic a, input logic [7:0] exp, input int req);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 chk(req, bus_rdata, exp);
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic int_chk(input logic exp, input int req);
        @(negedge clk); #1 chk(req, {7'b0, int_req}, {7'b0, exp});
    endtask

    task automatic ack_chk(input logic [7:0] exp, input int req);
        @(negedge clk); int_ack = 1'b1;
        @(posedge clk); #1 int_ack = 1'b0;
        chk(req, vec_out, exp);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        int_chk(1'b0, 1);
        chk(1, vec_out, 8'h00);
        rd_chk(1'b0, 8'h00, 1);
        rd_chk(1'b1, 8'h00, 1);

        for (int i = 0; i < 63; i++) begin
            case (TBL[i][22:20])
                WC: wr(1'b0, TBL[i][19:12]);
                WD: wr(1'b1, TBL[i][19:12]);
                SI: set_in(TBL[i][19:12]);
                AK: ack_chk(TBL[i][11:4], int'(TBL[i][3:0]));
                RC: rd_chk(1'b0, TBL[i][11:4], int'(TBL[i][3:0]));
                RD: rd_chk(1'b1, TBL[i][11:4], int'(TBL[i][3:0]));
                default: int_chk(TBL[i][4], int'(TBL[i][3:0]));
            endcase
        end

        // R9 automatic completion, cascade start-up with all four words (R2)
        wr(1'b0, 8'h11);
        int_chk(1'b0, 2);              // R2 quiet during start-up
        wr(1'b1, 8'h08);
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h03);
        chk(2, casc_cfg, 8'h04);       // R2 cascade byte kept
        set_in(8'h00);
        set_in(8'h06);
        int_chk(1'b1, 9);
        ack_chk(8'h09, 9);
        wr(1'b0, 8'h0B);
        rd_chk(1'b0, 8'h00, 9);        // R9 nothing left in service
        wr(1'b0, 8'h80);
        ack_chk(8'h0A, 9);             // lowest becomes 2
        set_in(8'h00);
        set_in(8'h09);
        ack_chk(8'h0B, 9);             // R9 level 3 now highest
        ack_chk(8'h08, 9);
        int_chk(1'b0, 9);

        // R4 level capture, start-up without mode word
        set_in(8'h10);
        wr(1'b0, 8'h1A);
        int_chk(1'b0, 2);              // R2 held during start-up
        wr(1'b1, 8'h60);
        int_chk(1'b1, 4);              // R4 level seen without new edge
        ack_chk(8'h64, 6);
        wr(1'b1, 8'hFF);               // mask, proving mode word skipped
        rd_chk(1'b1, 8'hFF, 2);
        int_chk(1'b0, 5);
        wr(1'b0, 8'h20);
        set_in(8'h00);
        ack_chk(8'h67, 6);             // R6 no request
        wr(1'b0, 8'h0A);
        set_in(8'h10);
        rd_chk(1'b0, 8'h10, 4);        // R4 follows input
        set_in(8'h00);
        rd_chk(1'b0, 8'h00, 4);

        // R13 special fully nested
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h11);
        set_in(8'h08);
        ack_chk(8'h03, 13);
        set_in(8'h00);
        set_in(8'h08);
        int_chk(1'b1, 13);

        summary();
        $finish;
    end
endmodule